// File: doc/BRIEF.md
# I2C Slave Receive Engine with Host-Decided Acknowledge

This block listens on the two wires of an I2C bus as a receive-only slave. It cleans both lines with a two-flop synchroniser and a short glitch filter, then finds START conditions (SDA falls while SCL is high) and STOP conditions (SDA rises while SCL is high). After each START it collects the first byte most significant bit first, compares the upper seven bits with a programmable own address, and recognises the all-zero general-call address as a separate case. Either hit sets its own status flag, raises a one-cycle interrupt request and acknowledges the address.

Data bytes follow. The host arms each byte with a write strobe whose data is a dummy. In automatic mode, an armed byte is acknowledged in the ninth clock and the interrupt follows once that clock has fallen. With the wait option set, the interrupt fires as soon as the eighth bit is in, and the acknowledge slot then carries a bit the host writes: 0 pulls SDA low (ACK) and 1 leaves it released (NACK). SDA is only ever pulled low, never driven high, and only changes while SCL is low. A STOP returns the engine to idle. The intended bus rate is 400 kHz fast mode.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, sda_low_o, irq_o, gen_call_o and addr_match_o are all 0.
- R2: When the seven bits received first after a START (bus bit order MSB first, the eighth bit being the direction bit) equal own_addr_i, addr_match_o becomes 1 and gen_call_o 0. A one-cycle irq_o is raised while the eighth SCL pulse is high, and sda_low_o is 1 during the ninth SCL pulse.
- R3: When those seven bits are all zero, gen_call_o becomes 1 and addr_match_o 0. An irq_o pulse is raised and the address is acknowledged as in R2.
- R4: For any other address, both flags become 0 and no irq_o is raised. SDA is not pulled low for the address or for any byte after it until the next START.
- R5: With wait_en_i = 0, an armed data byte is acknowledged (sda_low_o = 1) during the ninth SCL pulse. rx_data_o holds the byte (first bus bit in bit 7). irq_o pulses only after the ninth SCL falls, and sda_low_o is back to 0 after that fall.
- R6: With wait_en_i = 1, an armed byte raises irq_o while the eighth SCL pulse is high, with rx_data_o already valid. The ninth-clock level follows the ack_bit_i value captured by the last ack_set_i pulse: 0 gives sda_low_o = 1 and 1 gives sda_low_o = 0.
- R7: An arm_i pulse covers exactly one data byte. A byte received without an arm is neither acknowledged nor reported by irq_o. Multi-byte reception needs one arm per byte.
- R8: A STOP returns the engine to idle. SCL pulses that follow without a new START cause no acknowledge and no irq_o.
- R9: sda_low_o changes only while the filtered SCL is low, so the acknowledge level is set up before the ninth SCL rise.
- R10: A pulse on either bus line that is shorter than FILT_LEN clock cycles is ignored. A one-cycle SDA dip while SCL is high is neither a START nor a corrupted data bit.
- R11: irq_o is never high on two consecutive cycles, and gen_call_o and addr_match_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sampled from the pad |
| sda_i | input | 1 | Bus data line as sampled from the pad |
| sda_low_o | output | 1 | 1 pulls SDA low through the open-drain pad; 0 releases it |
| own_addr_i | input | 7 | Own 7-bit slave address |
| wait_en_i | input | 1 | 1 selects host-decided acknowledge with early interrupt |
| arm_i | input | 1 | Host write strobe arming the next data byte (data is a dummy) |
| ack_set_i | input | 1 | Host write strobe capturing ack_bit_i |
| ack_bit_i | input | 1 | Acknowledge bit for wait mode: 0 = ACK, 1 = NACK |
| rx_data_o | output | 8 | Last received data byte |
| gen_call_o | output | 1 | General-call address seen in the current transfer |
| addr_match_o | output | 1 | Own address seen in the current transfer |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The bus is driven with a matching own address, the general-call address and a foreign address, so the two flags and the silent case are each told apart from the others. Data bytes are sent armed and unarmed, in automatic and in wait mode, and with host bits of both values. The cycle at which each interrupt arrives is checked against the SCL phase, which separates the early wait-mode interrupt from the post-acknowledge one. Clocking without a START after a STOP and a one-cycle SDA dip inside a data bit show that only real bus conditions start a transfer.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_IGNORE
  } srx_state_e;
endpackage

// File: rtl/srx_line_filter.sv
module srx_line_filter #(
  parameter int   FILT_LEN = 4,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {2{RST_VAL}};
    else     sync_q <= {sync_q[0], line_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= RST_VAL;
      run_q <= '0;
    end else if (sync_q[1] == out_q) begin
      run_q <= '0;
    end else if (run_q == CW'(FILT_LEN - 1)) begin
      out_q <= sync_q[1];
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign line_o = out_q;

  // R10: the clean line only ever moves to the value the synchroniser held
  a_r10_filter_follows_sync: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_o) |-> (line_o == $past(sync_q[1])));
endmodule

// File: rtl/srx_bus_events.sv
module srx_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_o      = scl_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (shift_i) begin
        sh_q  <= {sh_q[W-2:0], bit_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) done_q <= 1'b1;
      end
    end
  end

  assign data_o = sh_q;
  assign done_o = done_q;

  // R5: the controller never clocks a ninth bit into a full byte
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(W));
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_srx_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_low_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              wait_en_i,
  input  logic              arm_i,
  input  logic              ack_set_i,
  input  logic              ack_bit_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              gen_call_o,
  output logic              addr_match_o,
  output logic              irq_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    srx_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .line_i(raw_lines[g]),
      .line_o(clean_lines[g])
    );
  end

  logic scl_lvl, scl_rise, scl_fall, ev_start, ev_stop;

  srx_bus_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (clean_lines[1]),
    .sda_i     (clean_lines[0]),
    .scl_o     (scl_lvl),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (ev_start),
    .stop_o    (ev_stop)
  );

  srx_state_e        state_q;
  logic [1:0]        ack_ph_q;
  logic              armed_q, want_ack_q, wait_byte_q, host_rdy_q, host_bit_q;
  logic              gc_q, am_q, irq_q, sda_low_q;
  logic [DATA_W-1:0] rx_q;

  logic              in_ack, ack_exit, shift_en, shift_clr, byte_done;
  logic [DATA_W-1:0] byte_w;
  logic              ack_level;

  assign in_ack    = (state_q == ST_ADDR_ACK) || (state_q == ST_DATA_ACK);
  assign ack_exit  = in_ack && (ack_ph_q == 2'd2) && scl_fall;
  assign shift_en  = scl_rise && ((state_q == ST_ADDR) || (state_q == ST_DATA));
  assign shift_clr = ev_start || ev_stop || ack_exit;
  assign ack_level = wait_byte_q ? (host_rdy_q & ~host_bit_q) : want_ack_q;

  srx_shifter #(.W(DATA_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (shift_clr),
    .shift_i(shift_en),
    .bit_i  (clean_lines[0]),
    .data_o (byte_w),
    .done_o (byte_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      ack_ph_q    <= 2'd0;
      armed_q     <= 1'b0;
      want_ack_q  <= 1'b0;
      wait_byte_q <= 1'b0;
      host_rdy_q  <= 1'b0;
      host_bit_q  <= 1'b1;
      gc_q        <= 1'b0;
      am_q        <= 1'b0;
      irq_q       <= 1'b0;
      sda_low_q   <= 1'b0;
      rx_q        <= '0;
    end else begin
      irq_q <= 1'b0;
      if (ev_stop) begin
        state_q   <= ST_IDLE;
        ack_ph_q  <= 2'd0;
        sda_low_q <= 1'b0;
      end else if (ev_start) begin
        state_q   <= ST_ADDR;
        ack_ph_q  <= 2'd0;
        sda_low_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: if (byte_done) begin
            want_ack_q  <= 1'b1;
            wait_byte_q <= 1'b0;
            if (byte_w[DATA_W-1:1] == '0) begin
              gc_q    <= 1'b1;
              am_q    <= 1'b0;
              irq_q   <= 1'b1;
              state_q <= ST_ADDR_ACK;
            end else if (byte_w[DATA_W-1:1] == own_addr_i) begin
              gc_q    <= 1'b0;
              am_q    <= 1'b1;
              irq_q   <= 1'b1;
              state_q <= ST_ADDR_ACK;
            end else begin
              gc_q    <= 1'b0;
              am_q    <= 1'b0;
              state_q <= ST_IGNORE;
            end
          end
          ST_DATA: if (byte_done) begin
            rx_q        <= byte_w;
            want_ack_q  <= armed_q;
            wait_byte_q <= armed_q & wait_en_i;
            irq_q       <= armed_q & wait_en_i;
            host_rdy_q  <= 1'b0;
            armed_q     <= 1'b0;
            state_q     <= ST_DATA_ACK;
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            unique case (ack_ph_q)
              2'd0: if (scl_fall) ack_ph_q <= 2'd1;
              2'd1: begin
                if (scl_rise)      ack_ph_q  <= 2'd2;
                else if (!scl_lvl) sda_low_q <= ack_level;
              end
              default: if (scl_fall) begin
                ack_ph_q  <= 2'd0;
                sda_low_q <= 1'b0;
                state_q   <= ST_DATA;
                if (state_q == ST_DATA_ACK && want_ack_q && !wait_byte_q)
                  irq_q <= 1'b1;
              end
            endcase
          end
          default: ;
        endcase
      end
      if (arm_i) armed_q <= 1'b1;
      if (ack_set_i) begin
        host_rdy_q <= 1'b1;
        host_bit_q <= ack_bit_i;
      end
    end
  end

  assign sda_low_o    = sda_low_q;
  assign irq_o        = irq_q;
  assign gen_call_o   = gc_q;
  assign addr_match_o = am_q;
  assign rx_data_o    = rx_q;

  // R9: pull-down level moves only in the SCL low phase (bus conditions aside)
  a_r9_sda_moves_low: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_low_o) && !$past(ev_start || ev_stop)) |-> !$past(scl_lvl));

  // R11: interrupt is a single-cycle pulse
  a_r11_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R11: the two address flags exclude each other
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gen_call_o && addr_match_o));

  // R4: a foreign address leaves the bus and the host alone
  a_r4_ignore_silent: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IGNORE) |-> (!sda_low_o && !irq_o));

  // R7: an unarmed byte is never acknowledged
  a_r7_unarmed_silent: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA_ACK && !want_ack_q) |-> !sda_low_o);
endmodule

// File: tb/test_i2c_slave_rx.sv
`timescale 1ns/1ps
module test_i2c_slave_rx;
  localparam int H = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_low_o;
  logic [6:0] own_addr_i = 7'h2A;
  logic       wait_en_i = 1'b0, arm_i = 1'b0, ack_set_i = 1'b0, ack_bit_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       gen_call_o, addr_match_o, irq_o;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_low_o;

  i2c_slave_rx i_i2c_slave_rx (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_low_o(sda_low_o),
    .own_addr_i(own_addr_i), .wait_en_i(wait_en_i), .arm_i(arm_i),
    .ack_set_i(ack_set_i), .ack_bit_i(ack_bit_i), .rx_data_o(rx_data_o),
    .gen_call_o(gen_call_o), .addr_match_o(addr_match_o), .irq_o(irq_o)
  );

  typedef struct {
    bit         gc;
    bit         am;
    bit         chk_data;
    logic [7:0] data;
    int         phase;
    bit [31:0]  tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0, irq_cnt = 0, phase = 0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input bit [31:0] tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input bit gc, input bit am, input bit cd, input logic [7:0] d,
                      input int ph, input bit [31:0] tag);
    exp_t e;
    e.gc = gc; e.am = am; e.chk_data = cd; e.data = d; e.phase = ph; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare every interrupt against the scoreboard
  always @(negedge clk) begin
    if (!rst && irq_o) begin
      exp_t e;
      irq_cnt++;
      chk(!(gen_call_o && addr_match_o), "R11", {gen_call_o, addr_match_o}, 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", irq_cnt, 0);
      end else begin
        e = exp_q.pop_front();
        chk(gen_call_o == e.gc && addr_match_o == e.am, e.tag,
            {gen_call_o, addr_match_o}, {e.gc, e.am});
        chk(phase == e.phase, e.tag, phase, e.phase);
        if (e.chk_data) chk(rx_data_o == e.data, e.tag, rx_data_o, e.data);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm();
    @(negedge clk); arm_i = 1'b1;
    @(negedge clk); arm_i = 1'b0;
  endtask

  task automatic bus_start();
    wait_n(H/2); sda_m = 1'b1;
    wait_n(H/2); scl_m = 1'b1;
    wait_n(H/2); sda_m = 1'b0;
    wait_n(H/2); scl_m = 1'b0; phase = 0;
  endtask

  task automatic bus_stop();
    wait_n(H/2); sda_m = 1'b0;
    wait_n(H/2); scl_m = 1'b1;
    wait_n(H/2); sda_m = 1'b1;
    wait_n(H);
  endtask

  // clocks one byte plus the acknowledge slot; host_ack < 0 means no host write
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input int host_ack,
                           input bit glitch, input bit [31:0] tag);
    for (int k = 1; k <= 8; k++) begin
      wait_n(H/2); sda_m = b[8-k];
      wait_n(H/2); scl_m = 1'b1; phase = 2*k - 1;
      wait_n(H/2);
      if (glitch && k == 3) begin
        sda_m = 1'b0; @(negedge clk); sda_m = 1'b1;
      end
      if (k == 8 && host_ack >= 0) begin
        ack_bit_i = host_ack[0]; ack_set_i = 1'b1;
        @(negedge clk); ack_set_i = 1'b0;
      end
      wait_n(H/2); scl_m = 1'b0; phase = 2*k;
    end
    wait_n(H/2); sda_m = 1'b1;
    wait_n(H/2 - 2);
    chk(sda_low_o == exp_ack, "R9", sda_low_o, exp_ack);
    wait_n(2); scl_m = 1'b1; phase = 17;
    wait_n(H/2);
    chk(sda_low_o == exp_ack, tag, sda_low_o, exp_ack);
    wait_n(H/2); scl_m = 1'b0; phase = 18;
    wait_n(H/2);
    chk(sda_low_o == 1'b0, "R5", sda_low_o, 0);
  endtask

  initial begin
    int base;
    wait_n(6);
    rst = 1'b0;
    wait_n(2);
    // R1: reset state
    chk(sda_low_o == 0 && irq_o == 0, "R1", {sda_low_o, irq_o}, 0);
    chk(gen_call_o == 0 && addr_match_o == 0, "R1", {gen_call_o, addr_match_o}, 0);

    // R2 own address, then R5 automatic bytes, R7 one arm per byte
    bus_start();
    push(0, 1, 0, 8'h00, 15, "R2");
    send_byte({7'h2A, 1'b0}, 1, -1, 0, "R2");
    arm();
    push(0, 1, 1, 8'hA5, 18, "R5");
    send_byte(8'hA5, 1, -1, 0, "R5");
    arm();
    push(0, 1, 1, 8'h3C, 18, "R7");
    send_byte(8'h3C, 1, -1, 0, "R7");
    bus_stop();

    // R3 general call, then R7 unarmed byte
    bus_start();
    push(1, 0, 0, 8'h00, 15, "R3");
    send_byte(8'h01, 1, -1, 0, "R3");
    arm();
    push(1, 0, 1, 8'h81, 18, "R3");
    send_byte(8'h81, 1, -1, 0, "R3");
    base = irq_cnt;
    send_byte(8'h7E, 0, -1, 0, "R7");
    chk(irq_cnt == base, "R7", irq_cnt, base);
    bus_stop();

    // R4 foreign address
    bus_start();
    base = irq_cnt;
    send_byte({7'h13, 1'b0}, 0, -1, 0, "R4");
    chk(gen_call_o == 0 && addr_match_o == 0, "R4", {gen_call_o, addr_match_o}, 0);
    arm();
    send_byte(8'hFF, 0, -1, 0, "R4");
    chk(irq_cnt == base, "R4", irq_cnt, base);
    bus_stop();

    // R6 wait mode with host ACK then host NACK
    wait_en_i = 1'b1;
    bus_start();
    push(0, 1, 0, 8'h00, 15, "R2");
    send_byte({7'h2A, 1'b1}, 1, -1, 0, "R2");
    arm();
    push(0, 1, 1, 8'h5A, 15, "R6");
    send_byte(8'h5A, 1, 0, 0, "R6");
    arm();
    push(0, 1, 1, 8'hC3, 15, "R6");
    send_byte(8'hC3, 0, 1, 0, "R6");
    bus_stop();
    wait_en_i = 1'b0;

    // R8 clocking after STOP without START
    base = irq_cnt;
    arm();
    send_byte(8'h99, 0, -1, 0, "R8");
    chk(irq_cnt == base, "R8", irq_cnt, base);

    // R10 one-cycle SDA dip while SCL is high
    bus_start();
    push(0, 1, 0, 8'h00, 15, "R2");
    send_byte({7'h2A, 1'b0}, 1, -1, 0, "R2");
    arm();
    push(0, 1, 1, 8'hFF, 18, "R10");
    send_byte(8'hFF, 1, -1, 1, "R10");
    bus_stop();

    wait_n(20);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule